// File: doc/BRIEF.md
# External Data Space Router with Nonvolatile Write Stall

This block sits between a processor's external-data load/store port and three targets: a small internal nonvolatile data array, an internal program flash array, and the external memory bus. Each accepted request is steered by three mode inputs and the pointer width used. Read data comes back through a multiplexer that follows the target latched at acceptance.

Reads from the internal arrays return with the same one-cycle latency as an external read. A write to either internal array is long. The block raises a stall output for `WRITE_CYCLES` cycles and ignores every request for that whole time. When the stall drops, the processor resumes with the instruction after the write. Writes to the external bus never stall.

Both internal arrays are plain synchronous memory models. The program array holds `2**PRG_AW` bytes and repeats across its 8 KB window.

Top module: `xdata_router`

## Requirements
- R1: With `force_ext`=1, every accepted request goes to the external bus (`ext_req`=1), at any address and for any value of `prog_sel` and `dflash_en`.
- R2: With `force_ext`=0, `prog_sel`=0 and `dflash_en`=1, a wide-pointer access to addresses 0x0000..0x00FF uses the 256-byte data array. Address 0x0100 and everything above it goes external.
- R3: With `force_ext`=0 and `prog_sel`=1, a wide-pointer access to 0x0000..0x1FFF uses the program array whatever `dflash_en` is, and 0x2000 and above goes external. The program array repeats every `2**PRG_AW` bytes inside that window.
- R4: With `force_ext`=0, `prog_sel`=0 and `dflash_en`=0, every address goes external.
- R5: A request with `wide_ptr`=0 (8-bit register pointer) always goes external, even inside an internal window.
- R6: For an accepted read, `rvalid` is 1 and `rdata` holds the read value in the cycle after acceptance, for internal and external targets alike. External data is taken from `ext_rdata` in that cycle.
- R7: An accepted write to an internal array holds `stall` high for exactly `WRITE_CYCLES` cycles, starting the cycle after acceptance. A later read returns the written byte.
- R8: While `stall` is high, requests are ignored: no `ext_req`, no `rvalid` and no array write.
- R9: An accepted external write drives `ext_we`, `ext_addr` and `ext_wdata` in the request cycle and does not raise `stall`.
- R10: After reset, `stall`, `rvalid` and `ext_req` are 0.
- R11: An accepted request routed internally leaves `ext_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_ext | input | 1 | Route everything external |
| prog_sel | input | 1 | Map the program array at the bottom of the space |
| dflash_en | input | 1 | Map the data array at the bottom of the space |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| wide_ptr | input | 1 | 1 = 16-bit pointer, 0 = 8-bit register pointer |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid |
| stall | output | 1 | Processor held idle during a nonvolatile write |
| ext_req | output | 1 | External bus request |
| ext_we | output | 1 | External bus write enable |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_rdata | input | 8 | External read data, valid the cycle after ext_req |

## Verification
Some rules are checked by the assertions on every cycle:
- forced or narrow-pointer requests always reach the external bus;
- no bus request appears while stalled;
- internal writes raise the stall on the next cycle, and external writes do not;
- a stall never lasts longer than `WRITE_CYCLES`;
- `rvalid` follows exactly the accepted reads.

Other behaviour only the bench scenarios can show:
- the exact window edges (0x00FF/0x0100, 0x1FFF/0x2000);
- that the stall lasts the full count;
- that written bytes read back, including through the program array's mirror;
- that writes attempted during a stall leave the arrays unchanged.

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int DFL_AW       = 8,
  parameter int PRG_WIN_AW   = 13,
  parameter int PRG_AW       = 11,
  parameter int WRITE_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        force_ext,
  input  logic        prog_sel,
  input  logic        dflash_en,
  input  logic        req,
  input  logic        we,
  input  logic        wide_ptr,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rvalid,
  output logic        stall,
  output logic        ext_req,
  output logic        ext_we,
  output logic [15:0] ext_addr,
  output logic [7:0]  ext_wdata,
  input  logic [7:0]  ext_rdata
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [1:0] TG_EXT = 2'd0, TG_DFL = 2'd1, TG_PRG = 2'd2;

  logic [1:0]       tgt, tgt_q;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       dfl_rd, prg_rd;
  logic [7:0]       dfl_mem [1<<DFL_AW];
  logic [7:0]       prg_mem [1<<PRG_AW];

  wire busy   = (cnt != '0);
  wire accept = req && !busy;
  wire in_dfl = (addr >> DFL_AW) == '0;
  wire in_prg = (addr >> PRG_WIN_AW) == '0;

  always_comb begin
    tgt = TG_EXT;
    if (!force_ext && wide_ptr) begin
      if (prog_sel) begin
        if (in_prg) tgt = TG_PRG;
      end else if (dflash_en && in_dfl) begin
        tgt = TG_DFL;
      end
    end
  end

  assign ext_req   = accept && (tgt == TG_EXT);
  assign ext_we    = we;
  assign ext_addr  = addr;
  assign ext_wdata = wdata;
  assign stall     = busy;

  always_ff @(posedge clk) begin
    if (accept && tgt == TG_DFL) begin
      if (we) dfl_mem[addr[DFL_AW-1:0]] <= wdata;
      else    dfl_rd <= dfl_mem[addr[DFL_AW-1:0]];
    end
    if (accept && tgt == TG_PRG) begin
      if (we) prg_mem[addr[PRG_AW-1:0]] <= wdata;
      else    prg_rd <= prg_mem[addr[PRG_AW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rvalid <= 1'b0;
      tgt_q  <= TG_EXT;
    end else begin
      rvalid <= accept && !we;
      if (accept) tgt_q <= tgt;
      if (accept && we && tgt != TG_EXT) cnt <= CNT_W'(WRITE_CYCLES);
      else if (busy)                     cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    case (tgt_q)
      TG_DFL:  rdata = dfl_rd;
      TG_PRG:  rdata = prg_rd;
      default: rdata = ext_rdata;
    endcase
  end
endmodule

// File: rtl/xdata_router_chk.sv
module xdata_router_chk #(
  parameter int WRITE_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic force_ext,
  input logic req,
  input logic we,
  input logic wide_ptr,
  input logic rvalid,
  input logic stall,
  input logic ext_req
);
  logic [31:0] scnt;
  always_ff @(posedge clk) begin
    if (!rst_n)     scnt <= '0;
    else if (stall) scnt <= scnt + 1;
    else            scnt <= '0;
  end

  a_r1_force_external: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !stall && force_ext) |-> ext_req);
  a_r5_narrow_external: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !stall && !wide_ptr) |-> ext_req);
  a_r8_quiet_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !ext_req);
  a_r7_internal_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !stall && we && !ext_req) |=> stall);
  a_r9_external_write_free: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !stall && we && ext_req) |=> !stall);
  a_r7_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (scnt < WRITE_CYCLES));
  a_r6_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !stall && !we) |=> rvalid);
  a_r6_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(req && !stall && !we));
  a_r11_internal_needs_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !stall && !ext_req) |-> (wide_ptr && !force_ext));
endmodule

bind xdata_router xdata_router_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .force_ext(force_ext), .req(req), .we(we),
  .wide_ptr(wide_ptr), .rvalid(rvalid), .stall(stall), .ext_req(ext_req)
);

// File: tb/test_xdata_router.sv
`timescale 1ns/1ps
module test_xdata_router;
  localparam int WC = 12;
  logic clk = 0, rst_n = 0;
  logic force_ext = 0, prog_sel = 0, dflash_en = 0;
  logic req = 0, we = 0, wide_ptr = 1;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0, rdata, ext_rdata = 0, ext_wdata;
  logic rvalid, stall, ext_req, ext_we;
  logic [15:0] ext_addr;
  int checks = 0, errors = 0;
  int ext_wr_n = 0;
  logic [15:0] last_wa = 0;
  logic [7:0]  last_wd = 0;

  always #2.5 clk = ~clk;

  xdata_router #(.WRITE_CYCLES(WC)) i_xdata_router (
    .clk(clk), .rst_n(rst_n), .force_ext(force_ext), .prog_sel(prog_sel),
    .dflash_en(dflash_en), .req(req), .we(we), .wide_ptr(wide_ptr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .stall(stall), .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  function automatic logic [7:0] ext_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (ext_req && !ext_we) ext_rdata <= ext_val(ext_addr);
    if (ext_req && ext_we) begin
      ext_wr_n <= ext_wr_n + 1;
      last_wa  <= ext_addr;
      last_wd  <= ext_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mode(input logic fe, input logic ps, input logic de);
    force_ext = fe; prog_sel = ps; dflash_en = de;
  endtask

  task automatic do_rd(input logic wp, input logic [15:0] a,
                       output logic seen, output logic [7:0] d, output logic v);
    req = 1; we = 0; wide_ptr = wp; addr = a;
    #1 seen = ext_req;
    @(negedge clk) req = 0;
    d = rdata; v = rvalid;
  endtask

  task automatic do_wr(input logic wp, input logic [15:0] a, input logic [7:0] dv,
                       output logic seen, output int n);
    req = 1; we = 1; wide_ptr = wp; addr = a; wdata = dv;
    #1 seen = ext_req;
    @(negedge clk) req = 0; we = 0;
    n = 0;
    while (stall && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R10 stall", stall, 0);
    chk("R10 rvalid", rvalid, 0);
    chk("R10 ext_req", ext_req, 0);
  endtask

  task automatic t_data_window;
    logic s, v; logic [7:0] d; int n, w0;
    mode(0, 0, 1);
    do_wr(1, 16'h0042, 8'hA5, s, n);
    chk("R2 write internal", s, 0);
    chk("R7 stall length", n, WC);
    do_rd(1, 16'h0042, s, d, v);
    chk("R2 read internal", s, 0);
    chk("R7 readback", d, 8'hA5);
    chk("R6 rvalid", v, 1);
    do_wr(1, 16'h00FF, 8'h3C, s, n);
    chk("R2 top byte internal", s, 0);
    do_rd(1, 16'h00FF, s, d, v);
    chk("R2 top byte readback", d, 8'h3C);
    do_rd(1, 16'h0100, s, d, v);
    chk("R2 0x0100 external", s, 1);
    chk("R6 external data", d, ext_val(16'h0100));
    w0 = ext_wr_n;
    do_wr(1, 16'h0100, 8'hC3, s, n);
    chk("R9 no stall", n, 0);
    chk("R9 ext write seen", ext_wr_n - w0, 1);
    chk("R9 ext addr", last_wa, 16'h0100);
    chk("R9 ext data", last_wd, 8'hC3);
  endtask

  task automatic t_narrow;
    logic s, v; logic [7:0] d;
    mode(0, 0, 1);
    do_rd(0, 16'h0042, s, d, v);
    chk("R5 narrow external", s, 1);
    chk("R5 narrow data", d, ext_val(16'h0042));
  endtask

  task automatic t_no_dflash;
    logic s, v; logic [7:0] d;
    mode(0, 0, 0);
    do_rd(1, 16'h0042, s, d, v);
    chk("R4 external", s, 1);
    chk("R4 data", d, ext_val(16'h0042));
  endtask

  task automatic t_prog;
    logic s, v; logic [7:0] d; int n;
    mode(0, 1, 0);
    do_wr(1, 16'h1FFF, 8'h77, s, n);
    chk("R3 prog write internal", s, 0);
    chk("R7 prog stall length", n, WC);
    do_rd(1, 16'h1FFF, s, d, v);
    chk("R3 prog readback", d, 8'h77);
    do_rd(1, 16'h07FF, s, d, v);
    chk("R3 mirror", d, 8'h77);
    do_rd(1, 16'h2000, s, d, v);
    chk("R3 0x2000 external", s, 1);
    mode(0, 1, 1);
    do_rd(1, 16'h1FFF, s, d, v);
    chk("R3 dflash ignored", s, 0);
    chk("R3 dflash ignored data", d, 8'h77);
  endtask

  task automatic t_force;
    logic s, v; logic [7:0] d; int n;
    mode(1, 1, 1);
    do_rd(1, 16'h0042, s, d, v);
    chk("R1 low addr external", s, 1);
    chk("R1 data", d, ext_val(16'h0042));
    do_rd(1, 16'h1FFF, s, d, v);
    chk("R1 prog addr external", s, 1);
    do_wr(1, 16'h0010, 8'h99, s, n);
    chk("R1 write external", s, 1);
    chk("R1 write no stall", n, 0);
  endtask

  task automatic t_busy_ignore;
    logic s, v; logic [7:0] d; int n;
    mode(0, 0, 1);
    req = 1; we = 1; wide_ptr = 1; addr = 16'h0010; wdata = 8'h5A;
    @(negedge clk);
    chk("R8 stalled", stall, 1);
    we = 0; addr = 16'h0300;
    #1 chk("R8 no ext_req", ext_req, 0);
    @(negedge clk);
    chk("R8 no rvalid", rvalid, 0);
    we = 1; addr = 16'h0010; wdata = 8'hFF;
    @(negedge clk) req = 0; we = 0;
    n = 0;
    while (stall && n < 1000) begin n++; @(negedge clk); end
    chk("R11 idle after stall", ext_req, 0);
    do_rd(1, 16'h0010, s, d, v);
    chk("R8 array unchanged", d, 8'h5A);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_data_window();
    t_narrow();
    t_no_dflash();
    t_prog();
    t_force();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule